// File: doc/BRIEF.md
# Scratch Register Memory Writeback Unit

This unit sits beside a command processor's packet decoder and watches the stream of register writes that the decoder produces. It holds a memory base address, an update mask and the decode for a window of eight scratch registers. When a write lands in the window and the mask bit for that slot is set, the unit queues a single 32-bit memory write of the same value. The write goes to the base address plus four times the slot number.

The decoder presents one register write per cycle on a valid/ready port. A burst of consecutive registers, or a write to a pair of registers, arrives as a run of single writes in consecutive cycles, and each of them is tested on its own. Mirror requests wait in a small in-order queue and leave through a single-beat request/acknowledge memory port. The word is presented in big-endian byte order. When the queue is full the unit holds off further register writes, so no mirror request is lost.

Top module: `scratch_mirror_unit`

## Requirements
- R1: After reset the memory request is low, `wr_ready` is high, and the mask and base are zero, so a scratch write made before any setup produces no memory write.
- R2: A write to register index 0x0578+n (n = 0..7) is a scratch write to slot n. If mask bit n is set, a memory request for it is raised from the cycle after the write is accepted, provided the queue was empty.
- R3: A scratch write to slot n whose mask bit n is clear produces no memory write.
- R4: Index 0x01DC loads the update mask from data bits 7:0. Data bits 31:8 of that write have no effect on any mirror decision.
- R5: Index 0x01DD loads the 32-bit base. The mirror address is base + 4·n, taken modulo 2^32.
- R6: The memory word is the register value in big-endian byte lane order: `mem_data[7:0]` = value[31:24], `mem_data[15:8]` = value[23:16], `mem_data[23:16]` = value[15:8], `mem_data[31:24]` = value[7:0].
- R7: A write to any index outside 0x0578..0x057F never produces a memory write. This includes the neighbours 0x0577 and 0x0580 and the mask and base registers.
- R8: Each scratch write uses the mask and base as they stand after every earlier accepted write. An update made earlier in the same back-to-back burst applies to later elements of that burst.
- R9: Mirror requests leave in the order of their scratch writes and none are dropped. The queue holds 4 entries, and `wr_ready` is low while 4 requests are pending.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr` and `mem_data` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A register write is presented |
| wr_ready | output | 1 | Unit can accept a register write this cycle |
| wr_idx | input | 16 | Register index of the write |
| wr_data | input | 32 | Value written |
| mem_req | output | 1 | Memory write request pending |
| mem_ack | input | 1 | Memory side accepts the current request |
| mem_addr | output | 32 | Byte address of the mirror write |
| mem_data | output | 32 | Mirrored word in big-endian lane order |

## Verification
The bench targets the window edges. A decode that is off by one would mirror writes to 0x0577 or 0x0580, or would skip slot 7. It runs a burst starting one slot below a lone enabled slot: a design that tests the wrong mask bit mirrors the first element or drops the second. It places the base near the top of the address space, where an address adder that saturates or drops the carry puts the word in the wrong place. It also changes the mask and base in the middle of a burst, so a design that latches configuration once per burst is caught. Finally, it holds the acknowledge low until the queue fills. A design with a wrong full flag would lose the fifth request, and one that lets the head move under back-pressure would change the address before acceptance.

// File: rtl/smu_pkg.sv
package smu_pkg;

  localparam int unsigned WORD_W = 32;

  typedef struct packed {
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] data;
  } mirror_req_t;

  localparam int unsigned REQ_W = $bits(mirror_req_t);

  // Reorder a word so byte lane 0 carries the most significant byte.
  function automatic logic [WORD_W-1:0] to_big_endian(input logic [WORD_W-1:0] v);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < WORD_W/8; b++) begin
      r[b*8 +: 8] = v[(WORD_W/8-1-b)*8 +: 8];
    end
    return r;
  endfunction

  // Slot address: base plus four bytes per slot, modulo the word width.
  function automatic logic [WORD_W-1:0] slot_addr(input logic [WORD_W-1:0] base,
                                                  input logic [WORD_W-1:0] slot);
    return base + (slot << 2);
  endfunction

endpackage

// File: rtl/smu_decode.sv
module smu_decode #(
  parameter int unsigned IDX_W     = 16,
  parameter int unsigned NUM_SLOTS = 8,
  parameter logic [IDX_W-1:0] WIN_BASE = 16'h0578,
  parameter logic [IDX_W-1:0] MASK_IDX = 16'h01DC,
  parameter logic [IDX_W-1:0] BASE_IDX = 16'h01DD,
  localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [IDX_W-1:0]  idx,
  output logic              is_mask,
  output logic              is_base,
  output logic              in_window,
  output logic [SLOT_W-1:0] slot
);

  logic [IDX_W-1:0] offset;

  assign offset    = idx - WIN_BASE;
  assign in_window = (offset < IDX_W'(NUM_SLOTS));
  assign slot      = offset[SLOT_W-1:0];
  assign is_mask   = (idx == MASK_IDX);
  assign is_base   = (idx == BASE_IDX);

endmodule

// File: rtl/smu_ctrl_regs.sv
module smu_ctrl_regs
  import smu_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_fire,
  input  logic                 is_mask,
  input  logic                 is_base,
  input  logic [WORD_W-1:0]    wr_data,
  output logic [NUM_SLOTS-1:0] mask_q,
  output logic [WORD_W-1:0]    base_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      base_q <= '0;
    end else if (wr_fire) begin
      if (is_mask) mask_q <= wr_data[NUM_SLOTS-1:0];
      if (is_base) base_q <= wr_data;
    end
  end

  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_fire && is_mask) |=> $stable(mask_q)); // R4
  AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_fire && is_base) |=> $stable(base_q)); // R5

endmodule

// File: rtl/smu_fifo.sv
module smu_fifo #(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign head  = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CNT_W'(DEPTH))); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0)); // R9

endmodule

// File: rtl/scratch_mirror_unit.sv
module scratch_mirror_unit
  import smu_pkg::*;
#(
  parameter int unsigned IDX_W      = 16,
  parameter int unsigned NUM_SLOTS  = 8,
  parameter logic [IDX_W-1:0] WIN_BASE = 16'h0578,
  parameter logic [IDX_W-1:0] MASK_IDX = 16'h01DC,
  parameter logic [IDX_W-1:0] BASE_IDX = 16'h01DD,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter bit          BIG_ENDIAN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic              mem_req,
  input  logic              mem_ack,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_data
);

  localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  // Named internal events
  logic                 wr_fire;
  logic                 is_mask_wr, is_base_wr, in_window;
  logic [SLOT_W-1:0]    slot;
  logic [NUM_SLOTS-1:0] mask_q;
  logic [WORD_W-1:0]    base_q;
  logic                 slot_enabled;
  logic                 fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [WORD_W-1:0]    lane_data;
  mirror_req_t          push_entry, head_entry;

  assign wr_ready = !fifo_full;
  assign wr_fire  = wr_valid && wr_ready;

  smu_decode #(
    .IDX_W(IDX_W), .NUM_SLOTS(NUM_SLOTS),
    .WIN_BASE(WIN_BASE), .MASK_IDX(MASK_IDX), .BASE_IDX(BASE_IDX)
  ) u_decode (
    .idx(wr_idx), .is_mask(is_mask_wr), .is_base(is_base_wr),
    .in_window(in_window), .slot(slot)
  );

  smu_ctrl_regs #(.NUM_SLOTS(NUM_SLOTS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire),
    .is_mask(is_mask_wr), .is_base(is_base_wr), .wr_data(wr_data),
    .mask_q(mask_q), .base_q(base_q)
  );

  assign slot_enabled = mask_q[slot];
  assign fifo_push    = wr_fire && in_window && slot_enabled;

  generate
    if (BIG_ENDIAN) begin : g_big
      assign lane_data = to_big_endian(wr_data);
    end else begin : g_little
      assign lane_data = wr_data;
    end
  endgenerate

  assign push_entry.addr = slot_addr(base_q, WORD_W'(slot));
  assign push_entry.data = lane_data;

  smu_fifo #(.WIDTH(REQ_W), .DEPTH(FIFO_DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(fifo_push), .push_data(push_entry),
    .pop(fifo_pop), .head(head_entry),
    .full(fifo_full), .empty(fifo_empty)
  );

  assign mem_req  = !fifo_empty;
  assign mem_addr = head_entry.addr;
  assign mem_data = head_entry.data;
  assign fifo_pop = mem_req && mem_ack;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data))); // R10
  AST_REQ_FROM_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(fifo_push)); // R2
  AST_PUSH_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> (wr_valid && wr_ready)); // R9
  AST_NO_CTRL_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> !(is_mask_wr || is_base_wr)); // R7

endmodule

// File: tb/scratch_mirror_unit_test.sv
module scratch_mirror_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        mem_req;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // Expected mirror queue (bench model)
  logic [31:0] exp_addr [0:255];
  logic [31:0] exp_data [0:255];
  int eh = 0, et = 0;
  logic [7:0]  m_mask = '0;
  logic [31:0] m_base = '0;

  scratch_mirror_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_idx(wr_idx), .wr_data(wr_data), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [31:0] swapped(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  // Monitor every memory handshake against the bench model
  always begin
    @(negedge clk); #5;
    if (rst_n && mem_req && mem_ack) begin
      if (eh == et) begin
        check(1'b0, "R3 R7 unexpected mirror write addr", mem_addr, 32'h0);
      end else begin
        check(mem_addr == exp_addr[eh], "R5 R9 mirror address", mem_addr, exp_addr[eh]);
        check(mem_data == exp_data[eh], "R6 mirror data byte order", mem_data, exp_data[eh]);
        eh++;
      end
    end
  end

  task automatic model_accept(input logic [15:0] idx, input logic [31:0] val);
    if (idx == 16'h01DC) m_mask = val[7:0];
    else if (idx == 16'h01DD) m_base = val;
    else if (idx >= 16'h0578 && idx <= 16'h057F) begin
      int n = int'(idx - 16'h0578);
      if (m_mask[n]) begin
        exp_addr[et] = m_base + 32'(n) * 4;
        exp_data[et] = swapped(val);
        et++;
      end
    end
  endtask

  task automatic put(input logic [15:0] idx, input logic [31:0] val);
    @(negedge clk); #1;
    wr_valid = 1'b1; wr_idx = idx; wr_data = val;
    #4;
    while (!wr_ready) begin @(negedge clk); #5; end
    model_accept(idx, val);
  endtask

  task automatic idle();
    @(negedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic set_ack(input logic v);
    @(negedge clk); #1;
    mem_ack = v;
  endtask

  task automatic drain(input string tag);
    int w = 0;
    set_ack(1'b1);
    while ((eh != et || mem_req) && w < 300) begin @(negedge clk); #6; w++; end
    check(eh == et && !mem_req, tag, 32'(eh), 32'(et));
  endtask

  task automatic t_reset();
    @(negedge clk); #5;
    check(wr_ready == 1'b1, "R1 wr_ready after reset", 32'(wr_ready), 32'h1);
    check(mem_req == 1'b0, "R1 mem_req after reset", 32'(mem_req), 32'h0);
    put(16'h0579, 32'hAAAA5555);
    idle();
    repeat (3) @(negedge clk); #5;
    check(mem_req == 1'b0, "R1 no mirror with reset mask", 32'(mem_req), 32'h0);
  endtask

  task automatic t_basic();
    put(16'h01DD, 32'h1000_0000);
    put(16'h01DC, 32'h0000_0010);
    put(16'h057C, 32'h824C_E2B8);
    idle(); // sample point of this cycle is the cycle after acceptance
    #4;
    check(mem_req == 1'b1, "R2 request one cycle after accept", 32'(mem_req), 32'h1);
    check(mem_addr == 32'h1000_0010, "R2 R5 slot 4 address", mem_addr, 32'h1000_0010);
    check(mem_data == 32'hB8E2_4C82, "R6 big-endian lanes", mem_data, 32'hB8E2_4C82);
    drain("R2 basic drain");
  endtask

  task automatic t_mask_burst();
    put(16'h01DD, 32'h2000_0000);
    put(16'h01DC, 32'h0000_0010);
    put(16'h057B, 32'h1111_1111); // R3: bit 3 clear
    put(16'h057C, 32'h2222_2222); // mirrored to +16
    idle();
    drain("R3 masked burst drain");
  endtask

  task automatic t_all_slots();
    put(16'h01DD, 32'h3000_0040);
    put(16'h01DC, 32'h0000_00FF);
    for (int i = 0; i < 8; i++) put(16'h0578 + 16'(i), 32'hC0DE_0000 + 32'(i * 17));
    idle();
    drain("R9 all slots in order");
  endtask

  task automatic t_outside();
    put(16'h0577, 32'h0BAD_0001);
    put(16'h0580, 32'h0BAD_0002);
    put(16'h0000, 32'h0BAD_0003);
    put(16'h01DB, 32'h0BAD_0004);
    put(16'h057F, 32'h7777_0007); // mask still all-ones: slot 7 mirrors
    idle();
    drain("R7 only window writes mirror");
  endtask

  task automatic t_upper_mask();
    put(16'h01DC, 32'hFFFF_FF00); // R4: only bits 7:0 count
    put(16'h0578, 32'h4444_0000);
    put(16'h057F, 32'h4444_0007);
    idle();
    repeat (3) @(negedge clk); #5;
    check(mem_req == 1'b0, "R4 upper mask bits ignored", 32'(mem_req), 32'h0);
    put(16'h01DC, 32'h0000_0101);
    put(16'h0578, 32'h4444_1000);
    put(16'h0579, 32'h4444_1001);
    idle();
    drain("R4 low mask bit only");
  endtask

  task automatic t_wrap();
    put(16'h01DD, 32'hFFFF_FFF8);
    put(16'h01DC, 32'h0000_0008);
    put(16'h057B, 32'h5A5A_0003); // FFFFFFF8 + 12 wraps to 00000004
    idle();
    drain("R5 address wraparound");
    check(exp_addr[et-1] == 32'h0000_0004, "R5 model wrap", exp_addr[et-1], 32'h4);
  endtask

  task automatic t_inburst_update();
    put(16'h01DD, 32'h4000_0000);
    put(16'h01DC, 32'h0000_0004);
    put(16'h057A, 32'h6000_0001); // 40000008
    put(16'h01DD, 32'h5000_0000);
    put(16'h057A, 32'h6000_0002); // 50000008
    put(16'h01DC, 32'h0000_0000);
    put(16'h057A, 32'h6000_0003); // not mirrored
    idle();
    drain("R8 updates apply within burst");
  endtask

  task automatic t_backpressure();
    logic [31:0] held;
    set_ack(1'b0);
    put(16'h01DD, 32'h7000_0000);
    put(16'h01DC, 32'h0000_00FF);
    fork
      begin
        for (int i = 0; i < 5; i++) put(16'h0578 + 16'(i), 32'h9000_0000 + 32'(i));
        idle();
      end
      begin
        repeat (8) @(negedge clk); #5;
        check(wr_ready == 1'b0, "R9 wr_ready low with 4 pending", 32'(wr_ready), 32'h0);
        check(mem_addr == 32'h7000_0000, "R9 head is oldest", mem_addr, 32'h7000_0000);
        held = mem_data;
        repeat (3) @(negedge clk); #5;
        check(mem_req == 1'b1 && mem_data == held, "R10 request held until ack", mem_data, held);
        set_ack(1'b1);
      end
    join
    drain("R9 fifth request not dropped");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_mask_burst();
    t_all_slots();
    t_outside();
    t_upper_mask();
    t_wrap();
    t_inburst_update();
    t_backpressure();
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule